// File: doc/BRIEF.md
# Synchronous Serial Port Register and FIFO Controller

This block is the memory-mapped front end of a synchronous serial port. Software reaches it over a plain 32-bit register bus that has a word address, a write strobe, a read strobe and a data word. It holds a word-format register, a control register and a clock prescaler register. It also holds an interrupt enable mask and sticky event flags, and it answers reads in an identification window. Two FIFOs of 16-bit words, each eight deep by default, carry data between software and the serial transfer engine. The block sets no serial timing of its own.

The transfer engine takes transmit words through a valid/ready pop port and returns received words through a push port. It signals a receive timeout with a one-cycle pulse. The block derives status flags and two FIFO-level interrupt conditions. It latches a receive-overrun flag when the engine pushes into a full receive FIFO. One level-sensitive interrupt line combines the raw conditions with the enable mask.

Top module: `ssp_ctrl_top`

## Requirements
- R1: After reset both FIFOs are empty, the enable mask (offset 0x14) is 0, the raw interrupt register (offset 0x18) reads 0x8 and the status register (offset 0x0C) reads 0x03. The interrupt output is low.
- R2: A write to the data offset 0x08 pushes the low bits of the write data into the transmit FIFO. Only format[3:0]+1 bits are kept and the rest are zeroed. A data write while the transmit FIFO holds 8 words is dropped.
- R3: A read of offset 0x08 returns the oldest receive word and removes it on the same clock edge. When the receive FIFO is empty the read returns 0 and changes nothing.
- R4: The status register bits are: bit 0 when the transmit FIFO is empty, bit 1 when it is not full, bit 2 when the receive FIFO is not empty, bit 3 when the receive FIFO is full, and bit 4 (busy) while the transmit FIFO holds any word.
- R5: Raw interrupt bit 2 is high while the receive level is at least half the depth (4). Raw interrupt bit 3 is high while the transmit level is at most half the depth (4).
- R6: The interrupt output is high exactly when the raw interrupt register ANDed with the enable mask is nonzero. Offset 0x1C reads back that AND.
- R7: A write to offset 0x20 clears raw bits 0 and 1 wherever the write data has a 1. The write has no effect on bits 2 and 3.
- R8: Raw bit 0 (receive overrun) sets when the engine pushes while the receive FIFO holds 8 words and no data read happens in that cycle. The pushed word is discarded. Raw bit 1 (receive timeout) sets on a timeout pulse. Both bits stay set until they are cleared.
- R9: The prescaler (offset 0x10) keeps bits 7:0 of a write. The format register (offset 0x00) keeps bits 15:0. Offset 0x24 always reads 0.
- R10: Reads of 0xFE0 to 0xFFC return one identification byte per word: 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in rising address order.
- R11: Reads of unmapped offsets return 0. Writes to unmapped or read-only offsets change no state.
- R12: When a push and a pop reach one FIFO in the same cycle, its level is unchanged and word order is kept. The transmit pop port presents the oldest word, in write order.
- R13: The control register (offset 0x04) keeps bits 3:0 and drives them to the engine. The format and prescaler registers are also driven to the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Level interrupt |
| ctl_o | output | 4 | Control register contents |
| fmt_o | output | 16 | Format register contents |
| psc_o | output | 8 | Prescaler register contents |
| tx_pop_valid | output | 1 | Transmit FIFO holds a word |
| tx_pop_data | output | 16 | Oldest transmit word |
| tx_pop_ready | input | 1 | Engine takes the transmit word |
| rx_push_valid | input | 1 | Engine offers a received word |
| rx_push_data | input | 16 | Received word |
| rx_push_ready | output | 1 | Receive FIFO has room |
| rx_timeout_evt | input | 1 | Receive timeout pulse |

## Verification
The assertions assume that read and write strobes never occur in the same cycle and that a strobe stays high for one cycle per access. The bench issues each register access through its own task and leaves an idle cycle between accesses, so no two bus accesses overlap. The engine side is assumed to pop only on a valid word. The bench drives engine pops through a task that first checks that a word is present. Engine pushes into a full receive FIFO are made on purpose, to set the overrun condition.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   localparam int unsigned DW = 16;

   localparam int unsigned OFF_FMT  = 'h000;
   localparam int unsigned OFF_CTL  = 'h004;
   localparam int unsigned OFF_DATA = 'h008;
   localparam int unsigned OFF_STAT = 'h00C;
   localparam int unsigned OFF_PSC  = 'h010;
   localparam int unsigned OFF_IEN  = 'h014;
   localparam int unsigned OFF_IRAW = 'h018;
   localparam int unsigned OFF_IACT = 'h01C;
   localparam int unsigned OFF_ICLR = 'h020;
   localparam int unsigned OFF_DMA  = 'h024;
   localparam int unsigned OFF_ID   = 'hFE0;

   // raw interrupt bit order is decoded by software
   typedef struct packed {
      logic tx_low;
      logic rx_high;
      logic rx_tmo;
      logic rx_ovr;
   } irq_vec_t;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0: b = 8'h22;
         3'd1: b = 8'h10;
         3'd2: b = 8'h04;
         3'd3: b = 8'h00;
         3'd4: b = 8'h0D;
         3'd5: b = 8'hF0;
         3'd6: b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

   function automatic logic [DW-1:0] width_mask(input logic [3:0] sel);
      logic [DW:0] m;
      m = ((DW+1)'(1) << ({1'b0, sel} + 5'd1)) - (DW+1)'(1);
      return m[DW-1:0];
   endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned WIDTH = 16,
   parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] push_data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic [LW-1:0]    level_o,
   output logic             accept_o
);

   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   initial begin
      assert (DEPTH >= 2) else $error("ssp_fifo: DEPTH must be at least 2");
      assert (LW >= $clog2(DEPTH + 1)) else $error("ssp_fifo: LW too narrow");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LW-1:0]    level;
   logic             is_empty, is_full, do_pop, do_push;

   assign is_empty = (level == '0);
   assign is_full  = (level == LW'(DEPTH));
   assign do_pop   = pop_i && !is_empty;
   assign do_push  = push_i && (!is_full || do_pop);

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data_i;
   end

   assign head_o   = mem[rd_ptr];
   assign level_o  = level;
   assign accept_o = do_push;

   p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LW'(DEPTH));

   p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && level_o == LW'(DEPTH)) |=> level_o == LW'(DEPTH));

   p_pair_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && level_o != '0) |=> $stable(level_o));

endmodule

// File: rtl/ssp_irq.sv
module ssp_irq #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] tx_level_i,
   input  logic [LW-1:0] rx_level_i,
   input  logic          ovr_set_i,
   input  logic          tmo_set_i,
   input  logic          clr_we_i,
   input  logic [1:0]    clr_bits_i,
   output ssp_pkg::irq_vec_t raw_o,
   output logic [4:0]    stat_o
);

   localparam int unsigned HALF = DEPTH / 2;

   initial begin
      assert (HALF >= 1) else $error("ssp_irq: depth too small for thresholds");
   end

   logic ovr_q, tmo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         tmo_q <= 1'b0;
      end else begin
         if (ovr_set_i)                     ovr_q <= 1'b1;
         else if (clr_we_i && clr_bits_i[0]) ovr_q <= 1'b0;
         if (tmo_set_i)                     tmo_q <= 1'b1;
         else if (clr_we_i && clr_bits_i[1]) tmo_q <= 1'b0;
      end
   end

   always_comb begin
      raw_o.rx_ovr  = ovr_q;
      raw_o.rx_tmo  = tmo_q;
      raw_o.rx_high = (rx_level_i >= LW'(HALF));
      raw_o.tx_low  = (tx_level_i <= LW'(HALF));
   end

   assign stat_o[0] = (tx_level_i == '0);
   assign stat_o[1] = (tx_level_i != LW'(DEPTH));
   assign stat_o[2] = (rx_level_i != '0);
   assign stat_o[3] = (rx_level_i == LW'(DEPTH));
   assign stat_o[4] = (tx_level_i != '0);

   p_clr_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_bits_i[0] && !ovr_set_i) |=> !raw_o.rx_ovr);

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_o.rx_ovr && !(clr_we_i && clr_bits_i[0])) |=> raw_o.rx_ovr);

   p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_o.rx_tmo && !(clr_we_i && clr_bits_i[1])) |=> raw_o.rx_tmo);

endmodule

// File: rtl/ssp_ctrl_top.sv
module ssp_ctrl_top #(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned AW      = 12,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [11:0] bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq_o,
   output logic [3:0]  ctl_o,
   output logic [15:0] fmt_o,
   output logic [7:0]  psc_o,
   output logic        tx_pop_valid,
   output logic [15:0] tx_pop_data,
   input  logic        tx_pop_ready,
   input  logic        rx_push_valid,
   input  logic [15:0] rx_push_data,
   output logic        rx_push_ready,
   input  logic        rx_timeout_evt
);
   import ssp_pkg::*;

   localparam int unsigned LW = $clog2(DEPTH + 1);
   localparam int unsigned WA = AW - 2;

   initial begin
      assert (AW == 12) else $error("ssp_ctrl_top: window is 4 KiB, AW must be 12");
      assert (DW == 16) else $error("ssp_ctrl_top: word width fixed at 16");
   end

   logic [WA-1:0] wa;
   logic          id_hit;
   assign wa     = bus_addr[AW-1:2];
   assign id_hit = (bus_addr[AW-1:5] == (AW-5)'(OFF_ID >> 5));

   logic hit_fmt, hit_ctl, hit_data, hit_psc, hit_ien, hit_iclr;
   assign hit_fmt  = (wa == WA'(OFF_FMT  >> 2));
   assign hit_ctl  = (wa == WA'(OFF_CTL  >> 2));
   assign hit_data = (wa == WA'(OFF_DATA >> 2));
   assign hit_psc  = (wa == WA'(OFF_PSC  >> 2));
   assign hit_ien  = (wa == WA'(OFF_IEN  >> 2));
   assign hit_iclr = (wa == WA'(OFF_ICLR >> 2));

   logic [15:0] fmt_q;
   logic [3:0]  ctl_q;
   logic [7:0]  psc_q;
   logic [3:0]  ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= '0;
         ctl_q <= '0;
         psc_q <= '0;
         ien_q <= '0;
      end else if (bus_wr) begin
         if (hit_fmt) fmt_q <= bus_wdata[15:0];
         if (hit_ctl) ctl_q <= bus_wdata[3:0];
         if (hit_psc) psc_q <= bus_wdata[7:0];
         if (hit_ien) ien_q <= bus_wdata[3:0];
      end
   end

   logic [DW-1:0] tx_word;
   logic [LW-1:0] tx_level, rx_level;
   logic [DW-1:0] tx_head, rx_head;
   logic          tx_acc, rx_acc;
   logic          tx_push, rx_pop;

   assign tx_word = bus_wdata[DW-1:0] & width_mask(fmt_q[3:0]);
   assign tx_push = bus_wr && hit_data;
   assign rx_pop  = bus_rd && hit_data;

   ssp_fifo #(.DEPTH(DEPTH), .WIDTH(DW), .LW(LW)) u_txq (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (tx_push),
      .push_data_i (tx_word),
      .pop_i       (tx_pop_ready),
      .head_o      (tx_head),
      .level_o     (tx_level),
      .accept_o    (tx_acc)
   );

   ssp_fifo #(.DEPTH(DEPTH), .WIDTH(DW), .LW(LW)) u_rxq (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (rx_push_valid),
      .push_data_i (rx_push_data),
      .pop_i       (rx_pop),
      .head_o      (rx_head),
      .level_o     (rx_level),
      .accept_o    (rx_acc)
   );

   irq_vec_t   raw;
   logic [4:0] stat;

   ssp_irq #(.DEPTH(DEPTH), .LW(LW)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_level_i (tx_level),
      .rx_level_i (rx_level),
      .ovr_set_i  (rx_push_valid && !rx_acc),
      .tmo_set_i  (rx_timeout_evt),
      .clr_we_i   (bus_wr && hit_iclr),
      .clr_bits_i (bus_wdata[1:0]),
      .raw_o      (raw),
      .stat_o     (stat)
   );

   logic [3:0] active;
   assign active = raw & ien_q;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |active;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = |active;
         p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ien_q == '0) |-> !irq_o);
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (id_hit) begin
         bus_rdata[7:0] = id_byte(bus_addr[4:2]);
      end else begin
         case (wa)
            WA'(OFF_FMT  >> 2): bus_rdata[15:0] = fmt_q;
            WA'(OFF_CTL  >> 2): bus_rdata[3:0]  = ctl_q;
            WA'(OFF_DATA >> 2): bus_rdata[DW-1:0] = (rx_level == '0) ? '0 : rx_head;
            WA'(OFF_STAT >> 2): bus_rdata[4:0]  = stat;
            WA'(OFF_PSC  >> 2): bus_rdata[7:0]  = psc_q;
            WA'(OFF_IEN  >> 2): bus_rdata[3:0]  = ien_q;
            WA'(OFF_IRAW >> 2): bus_rdata[3:0]  = raw;
            WA'(OFF_IACT >> 2): bus_rdata[3:0]  = active;
            default:            bus_rdata       = '0;
         endcase
      end
   end

   assign ctl_o         = ctl_q;
   assign fmt_o         = fmt_q;
   assign psc_o         = psc_q;
   assign tx_pop_valid  = (tx_level != '0);
   assign tx_pop_data   = tx_head;
   assign rx_push_ready = (rx_level != LW'(DEPTH));

   logic unused_ok;
   assign unused_ok = ^{bus_addr[1:0], bus_wdata[31:16], tx_acc};

   p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_data && !id_hit && rx_level == '0) |-> (bus_rdata == '0));

   p_ctl_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ctl) |=> (ctl_o == $past(bus_wdata[3:0])));

   p_pop_needs_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rx_level != '0) |=> (rx_level == $past(rx_level) - 1'b1) || $past(rx_push_valid));

endmodule

// File: tb/sim_ssp_ctrl_top.sv
`timescale 1ns/1ps
module sim_ssp_ctrl_top;

   localparam logic [11:0] A_FMT  = 12'h000;
   localparam logic [11:0] A_CTL  = 12'h004;
   localparam logic [11:0] A_DATA = 12'h008;
   localparam logic [11:0] A_STAT = 12'h00C;
   localparam logic [11:0] A_PSC  = 12'h010;
   localparam logic [11:0] A_IEN  = 12'h014;
   localparam logic [11:0] A_IRAW = 12'h018;
   localparam logic [11:0] A_IACT = 12'h01C;
   localparam logic [11:0] A_ICLR = 12'h020;
   localparam logic [11:0] A_DMA  = 12'h024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic [3:0]  ctl_o;
   logic [15:0] fmt_o;
   logic [7:0]  psc_o;
   logic        tx_pop_valid;
   logic [15:0] tx_pop_data;
   logic        tx_pop_ready = 1'b0;
   logic        rx_push_valid = 1'b0;
   logic [15:0] rx_push_data = '0;
   logic        rx_push_ready;
   logic        rx_timeout_evt = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] m_exp;
   string       m_tag;

   always #5 clk = ~clk;

   ssp_ctrl_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .ctl_o(ctl_o),
      .fmt_o(fmt_o), .psc_o(psc_o), .tx_pop_valid(tx_pop_valid), .tx_pop_data(tx_pop_data),
      .tx_pop_ready(tx_pop_ready), .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data),
      .rx_push_ready(rx_push_ready), .rx_timeout_evt(rx_timeout_evt)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares every read strobe against the scoreboard queue
   always @(negedge clk) begin
      if (bus_rd) begin
         if (exp_q.size() == 0) begin
            chk(bus_rdata, 32'hDEAD_BEEF, "unexpected read");
         end else begin
            m_exp = exp_q.pop_front();
            m_tag = tag_q.pop_front();
            chk(bus_rdata, m_exp, m_tag);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic rd_push(input logic [31:0] e, input logic [15:0] pd, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_addr = A_DATA; bus_rd = 1'b1; rx_push_valid = 1'b1; rx_push_data = pd;
      @(posedge clk); #1;
      bus_rd = 1'b0; rx_push_valid = 1'b0;
   endtask

   task automatic eng_push(input logic [15:0] pd);
      @(posedge clk); #1;
      rx_push_valid = 1'b1; rx_push_data = pd;
      @(posedge clk); #1;
      rx_push_valid = 1'b0;
   endtask

   task automatic eng_pop(input logic [15:0] e, input string tag);
      @(posedge clk); #1;
      chk({31'd0, tx_pop_valid}, 32'd1, tag);
      chk({16'd0, tx_pop_data}, {16'd0, e}, tag);
      tx_pop_ready = 1'b1;
      @(posedge clk); #1;
      tx_pop_ready = 1'b0;
   endtask

   task automatic wr_pop(input logic [31:0] d, input logic [15:0] e, input string tag);
      @(posedge clk); #1;
      chk({16'd0, tx_pop_data}, {16'd0, e}, tag);
      bus_addr = A_DATA; bus_wdata = d; bus_wr = 1'b1; tx_pop_ready = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0; tx_pop_ready = 1'b0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] idb[8];
      idb = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk({31'd0, irq_o}, 32'd0, "R1 irq");
      chk({31'd0, tx_pop_valid}, 32'd0, "R1 tx valid");
      chk({31'd0, rx_push_ready}, 32'd1, "R1 rx ready");
      rd(A_STAT, 32'h03, "R1 status");
      rd(A_IRAW, 32'h08, "R1 raw");
      rd(A_IEN, 32'h00, "R1 enable");

      // R13 control outputs
      wr(A_FMT, 32'h7);
      wr(A_CTL, 32'hFFFF_FFF2);
      chk({28'd0, ctl_o}, 32'h2, "R13 ctl_o");
      chk({16'd0, fmt_o}, 32'h7, "R13 fmt_o");
      rd(A_CTL, 32'h2, "R13 ctl read");

      // R2 masking, R4 status
      wr(A_DATA, 32'h1A5);
      chk({16'd0, tx_pop_data}, 32'hA5, "R2 masked word");
      rd(A_STAT, 32'h12, "R4 one tx word");
      rd(A_IRAW, 32'h08, "R5 tx low");
      for (int i = 1; i < 8; i++) wr(A_DATA, 32'h100 + i);
      rd(A_STAT, 32'h10, "R4 tx full");
      rd(A_IRAW, 32'h00, "R5 tx above half");
      wr(A_DATA, 32'hEE);
      rd(A_STAT, 32'h10, "R2 full drop status");

      // R12 pop order
      eng_pop(16'hA5, "R12 pop 0");
      for (int i = 1; i < 4; i++) eng_pop(16'(i), "R12 pop order");
      rd(A_IRAW, 32'h08, "R5 tx at half");
      for (int i = 4; i < 8; i++) eng_pop(16'(i), "R12 pop order");
      chk({31'd0, tx_pop_valid}, 32'd0, "R2 dropped word absent");
      rd(A_STAT, 32'h03, "R4 tx drained");

      // R2 widths
      wr(A_FMT, 32'h3);
      wr(A_DATA, 32'hFFFF);
      eng_pop(16'h000F, "R2 four-bit word");
      wr(A_FMT, 32'hF);
      wr(A_DATA, 32'hFFFF);
      eng_pop(16'hFFFF, "R2 sixteen-bit word");

      // R12 transmit push and pop together
      wr(A_DATA, 32'h11);
      wr_pop(32'h22, 16'h11, "R12 tx head before pair");
      chk({31'd0, tx_pop_valid}, 32'd1, "R12 tx level kept");
      chk({16'd0, tx_pop_data}, 32'h22, "R12 tx next word");
      rd(A_STAT, 32'h12, "R12 tx level one");
      eng_pop(16'h22, "R12 tx last");

      // R5 R6 receive threshold and interrupt
      eng_push(16'h11); eng_push(16'h22); eng_push(16'h33);
      rd(A_IRAW, 32'h08, "R5 rx below half");
      eng_push(16'h44);
      rd(A_IRAW, 32'h0C, "R5 rx at half");
      rd(A_STAT, 32'h07, "R4 rx not empty");
      wr(A_IEN, 32'h4);
      chk({31'd0, irq_o}, 32'd1, "R6 irq rx");
      rd(A_IACT, 32'h4, "R6 active rx");
      wr(A_IEN, 32'h0);
      chk({31'd0, irq_o}, 32'd0, "R6 irq masked");
      rd(A_IACT, 32'h0, "R6 active none");
      wr(A_IEN, 32'h8);
      chk({31'd0, irq_o}, 32'd1, "R6 irq tx");
      wr(A_IEN, 32'h0);

      // R8 overrun
      eng_push(16'h55); eng_push(16'h66); eng_push(16'h77); eng_push(16'h88);
      rd(A_STAT, 32'h0F, "R4 rx full");
      chk({31'd0, rx_push_ready}, 32'd0, "R8 ready low when full");
      eng_push(16'h99);
      rd(A_IRAW, 32'h0D, "R8 overrun set");

      // R3 read order and empty read
      rd(A_DATA, 32'h11, "R3 read 1");
      rd(A_DATA, 32'h22, "R3 read 2");
      rd(A_DATA, 32'h33, "R3 read 3");
      rd(A_DATA, 32'h44, "R3 read 4");
      rd(A_DATA, 32'h55, "R3 read 5");
      rd(A_DATA, 32'h66, "R3 read 6");
      rd(A_DATA, 32'h77, "R3 read 7");
      rd(A_DATA, 32'h88, "R3 read 8 no overrun word");
      rd(A_DATA, 32'h00, "R3 empty read");
      rd(A_STAT, 32'h03, "R3 empty read no effect");
      rd(A_IRAW, 32'h09, "R8 overrun sticky");

      // R7 R8 timeout and clear
      @(posedge clk); #1 rx_timeout_evt = 1'b1;
      @(posedge clk); #1 rx_timeout_evt = 1'b0;
      rd(A_IRAW, 32'h0B, "R8 timeout set");
      wr(A_ICLR, 32'hC);
      rd(A_IRAW, 32'h0B, "R7 clear upper bits no effect");
      wr(A_ICLR, 32'h1);
      rd(A_IRAW, 32'h0A, "R7 clear overrun");
      wr(A_ICLR, 32'h2);
      rd(A_IRAW, 32'h08, "R7 clear timeout");
      eng_push(16'hA1); eng_push(16'hA2); eng_push(16'hA3); eng_push(16'hA4);
      wr(A_ICLR, 32'hF);
      rd(A_IRAW, 32'h0C, "R7 level bits kept");
      rd(A_DATA, 32'hA1, "R3 read a1");
      rd(A_DATA, 32'hA2, "R3 read a2");
      rd(A_DATA, 32'hA3, "R3 read a3");
      rd(A_DATA, 32'hA4, "R3 read a4");

      // R12 receive push and pop together
      eng_push(16'h01); eng_push(16'h02);
      rd_push(32'h01, 16'h03, "R12 rx pair head");
      rd(A_DATA, 32'h02, "R12 rx order 2");
      rd(A_DATA, 32'h03, "R12 rx order 3");
      rd(A_DATA, 32'h00, "R12 rx level back to 0");
      rd(A_IRAW, 32'h08, "R12 no overrun");

      // R9 register widths
      wr(A_PSC, 32'h1234);
      rd(A_PSC, 32'h34, "R9 prescaler");
      chk({24'd0, psc_o}, 32'h34, "R9 psc_o");
      wr(A_DMA, 32'hFF);
      rd(A_DMA, 32'h0, "R9 dma reads zero");

      // R10 identification
      for (int k = 0; k < 8; k++)
         rd(12'hFE0 + 12'(4 * k), {24'd0, idb[k]}, "R10 id byte");

      // R11 unmapped and read-only offsets
      wr(12'h028, 32'hFFFF_FFFF);
      wr(12'h800, 32'hFFFF_FFFF);
      wr(A_STAT, 32'hFF);
      wr(A_IRAW, 32'hFF);
      wr(A_IACT, 32'hFF);
      rd(12'h028, 32'h0, "R11 read 028");
      rd(12'h800, 32'h0, "R11 read 800");
      rd(A_STAT, 32'h03, "R11 status kept");
      rd(A_IRAW, 32'h08, "R11 raw kept");
      rd(A_IEN, 32'h0, "R11 enable kept");
      rd(A_PSC, 32'h34, "R11 prescaler kept");
      rd(A_CTL, 32'h2, "R11 ctl kept");
      rd(A_FMT, 32'hF, "R11 fmt kept");
      chk({31'd0, irq_o}, 32'd0, "R11 irq kept");
      chk({31'd0, tx_pop_valid}, 32'd0, "R11 tx empty kept");

      wr(A_FMT, 32'hFFFF_ABCD);
      rd(A_FMT, 32'hABCD, "R9 format keeps 16 bits");

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'd0, "scoreboard drained");
      finish_run();
   end

endmodule